// File: doc/BRIEF.md
# Link Speed Bring-Up Controller

This block sequences the bring-up of a two-speed serial link. When started, it caps the controller's advertised maximum speed at the first generation and only then enables link training. Once the link reports up, and if the second generation was requested, it raises the speed cap, issues a directed speed change and polls, with a bounded number of spaced reads, until the hardware clears the change request. It then waits for the link to come back up and reads the negotiated generation from the link status word. The link training state machine itself lives elsewhere; this block only drives its enable and watches its link-up flag.

All controller accesses go through a simple request/acknowledge register master port. PHY accesses go through a second port of the same kind. A link-up timeout or an exhausted poll sends the block into a recovery path. That path sets two receiver override bits in a PHY register with a read-modify-write, holds them for a programmable time of a few milliseconds, and clears them again with a second read-modify-write. A skip input bypasses the speed-change poll for controller variants that leave the change bit set when the speed does not actually change.

Both ports use the same handshake. A request stays high, with its address, write flag and write data stable, until the cycle in which acknowledge is high. Read data is valid in that same cycle.

Top module: `link_speed_bringup`

## Requirements
- R1: After reset `done`, `fail`, `trainEn`, `rxRecover`, `cfgReq` and `phyReq` are low and `linkGen` is 0.
- R2: On `start` the block reads configuration offset 0x07C and writes it back with bits 3:0 set to 1 and all other bits unchanged. `trainEn` rises only after that write has been acknowledged.
- R3: While waiting for link-up the block allows LINK_WAIT cycles, counted from the cycle after `trainEn` rises. A `linkUp` seen in the last of those cycles counts as success. If no link-up is seen within them, the block takes the recovery path and drops `trainEn`.
- R4: With `targetGen` equal to 2, the first link-up is followed by a read-modify-write of offset 0x07C that sets bits 3:0 to 2. After that comes a read-modify-write of offset 0x80C that sets bit 17 and keeps the other bits.
- R5: Without skip, offset 0x80C is re-read until bit 17 reads 0, with POLL_GAP idle cycles between reads and at most POLL_LIMIT reads. If every read shows bit 17 set, the block takes the recovery path.
- R6: With `skipSpeedPoll` high when the bit 17 write is acknowledged, offset 0x80C is not read again after that write.
- R7: After the speed change the block waits for link-up again with the same timeout. `done` is never raised before that second link-up, and a timeout there takes the recovery path.
- R8: On success `linkGen` takes bits 19:16 of the word read from offset 0x80. It is cleared to 0 on `start`.
- R9: The recovery path reads PHY address 0x1005 and writes it back with bits 5 and 3 set and the other bits kept. It waits at least HOLD_CYC cycles, then reads the register and writes it back with bits 5 and 3 cleared. `rxRecover` is high only between the two writes.
- R10: `done` and `fail` are levels cleared by `start`. Success sets `done` alone, and the recovery path sets both together. With `targetGen` not equal to 2, the block finishes after the first link-up without accessing offset 0x80C.
- R11: A `start` pulse while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a bring-up run |
| targetGen | input | 2 | Requested generation; 2 enables the speed upgrade |
| linkUp | input | 1 | Link-up status from the training logic |
| skipSpeedPoll | input | 1 | Bypass the speed-change completion poll |
| trainEn | output | 1 | Enable for link training |
| done | output | 1 | Run finished (level) |
| fail | output | 1 | Run finished through the recovery path (level) |
| linkGen | output | 4 | Negotiated generation from the status word |
| rxRecover | output | 1 | Receiver override window is active |
| cfgReq | output | 1 | Configuration access request |
| cfgWe | output | 1 | Configuration access is a write |
| cfgAddr | output | CFG_AW | Configuration byte offset |
| cfgWdata | output | CFG_DW | Configuration write data |
| cfgRdata | input | CFG_DW | Configuration read data, valid with cfgAck |
| cfgAck | input | 1 | Configuration access acknowledge |
| phyReq | output | 1 | PHY access request |
| phyWe | output | 1 | PHY access is a write |
| phyAddr | output | PHY_AW | PHY register address |
| phyWdata | output | PHY_DW | PHY write data |
| phyRdata | input | PHY_DW | PHY read data, valid with phyAck |
| phyAck | input | 1 | PHY access acknowledge |

## Verification
Two pairs of decisions can land in the same cycle. In the first, a link-up can arrive in the final cycle of the wait window, exactly when the timeout would fire. The bench raises link-up in that last cycle and then, in a separate run, one cycle later, counting from the edge where training enable rises; the first run must end in success and the second in the recovery path. In the second pair, the final permitted poll read can also be the one that finds the change bit cleared. The bench's register model clears the bit after a programmed number of reads, which places that read against the poll limit, and it counts the reads to judge that clear wins over exhaustion.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  // Width of the maximum-speed field and of the reported generation
  localparam int SPEED_FW = 4;
  // Controller configuration offsets and bit positions used by the sequence
  localparam int CAP_OFS      = 'h07C;
  localparam int STS_OFS      = 'h080;
  localparam int SPD_OFS      = 'h80C;
  localparam int SPD_BIT      = 17;
  localparam int STS_GEN_LSB  = 16;
  // PHY receiver override register and its two enable bits
  localparam int PHY_OVR_ADDR = 'h1005;
  localparam int OVR_DATA_BIT = 5;
  localparam int OVR_PLL_BIT  = 3;

  typedef enum logic [3:0] {
    ACC_NONE, ACC_CAP_RD, ACC_CAP_LO, ACC_CAP_HI, ACC_SPD_RD,
    ACC_SPD_SET, ACC_STS_RD, ACC_PHY_RD, ACC_PHY_SET, ACC_PHY_CLR
  } acc_e;

  typedef struct packed {
    acc_e acc;
    logic clrGen;
  } dp_cmd_t;

  typedef enum logic [4:0] {
    S_IDLE, S_CAP_RD1, S_CAP_WR1, S_WAIT1, S_CAP_RD2, S_CAP_WR2,
    S_SPD_RD, S_SPD_WR, S_POLL, S_GAP, S_WAIT2, S_STS_RD,
    S_OVR_RD1, S_OVR_WR1, S_HOLD, S_OVR_RD2, S_OVR_WR2
  } st_e;
endpackage

// File: rtl/lsb_datapath.sv
module lsb_datapath
  import lsb_pkg::*;
#(
  parameter int CFG_AW = 12,
  parameter int CFG_DW = 32,
  parameter int PHY_AW = 16,
  parameter int PHY_DW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_cmd_t             cmd,
  output logic                cfgReq,
  output logic                cfgWe,
  output logic [CFG_AW-1:0]   cfgAddr,
  output logic [CFG_DW-1:0]   cfgWdata,
  input  logic [CFG_DW-1:0]   cfgRdata,
  input  logic                cfgAck,
  output logic                phyReq,
  output logic                phyWe,
  output logic [PHY_AW-1:0]   phyAddr,
  output logic [PHY_DW-1:0]   phyWdata,
  input  logic [PHY_DW-1:0]   phyRdata,
  input  logic                phyAck,
  output logic                spdBusy,
  output logic [SPEED_FW-1:0] linkGen
);
  localparam logic [CFG_DW-1:0] SPD_MASK = CFG_DW'(1) << SPD_BIT;
  localparam logic [PHY_DW-1:0] OVR_MASK =
    (PHY_DW'(1) << OVR_DATA_BIT) | (PHY_DW'(1) << OVR_PLL_BIT);

  logic [CFG_DW-1:0] shadowQ;
  logic              cfgRead;

  assign cfgRead = (cmd.acc == ACC_CAP_RD) || (cmd.acc == ACC_SPD_RD);
  assign spdBusy = cfgRdata[SPD_BIT];
  assign phyAddr = PHY_AW'(PHY_OVR_ADDR);

  always_comb begin
    cfgReq   = 1'b0;
    cfgWe    = 1'b0;
    cfgAddr  = '0;
    cfgWdata = '0;
    phyReq   = 1'b0;
    phyWe    = 1'b0;
    phyWdata = '0;
    case (cmd.acc)
      ACC_CAP_RD: begin
        cfgReq  = 1'b1;
        cfgAddr = CFG_AW'(CAP_OFS);
      end
      ACC_CAP_LO: begin
        cfgReq   = 1'b1;
        cfgWe    = 1'b1;
        cfgAddr  = CFG_AW'(CAP_OFS);
        cfgWdata = {shadowQ[CFG_DW-1:SPEED_FW], SPEED_FW'(1)};
      end
      ACC_CAP_HI: begin
        cfgReq   = 1'b1;
        cfgWe    = 1'b1;
        cfgAddr  = CFG_AW'(CAP_OFS);
        cfgWdata = {shadowQ[CFG_DW-1:SPEED_FW], SPEED_FW'(2)};
      end
      ACC_SPD_RD: begin
        cfgReq  = 1'b1;
        cfgAddr = CFG_AW'(SPD_OFS);
      end
      ACC_SPD_SET: begin
        cfgReq   = 1'b1;
        cfgWe    = 1'b1;
        cfgAddr  = CFG_AW'(SPD_OFS);
        cfgWdata = shadowQ | SPD_MASK;
      end
      ACC_STS_RD: begin
        cfgReq  = 1'b1;
        cfgAddr = CFG_AW'(STS_OFS);
      end
      ACC_PHY_RD: phyReq = 1'b1;
      ACC_PHY_SET: begin
        phyReq   = 1'b1;
        phyWe    = 1'b1;
        phyWdata = shadowQ[PHY_DW-1:0] | OVR_MASK;
      end
      ACC_PHY_CLR: begin
        phyReq   = 1'b1;
        phyWe    = 1'b1;
        phyWdata = shadowQ[PHY_DW-1:0] & ~OVR_MASK;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ <= '0;
      linkGen <= '0;
    end else begin
      if (cfgAck && cfgRead) shadowQ <= cfgRdata;
      if (phyAck && (cmd.acc == ACC_PHY_RD)) shadowQ <= CFG_DW'(phyRdata);
      if (cmd.clrGen) linkGen <= '0;
      else if (cfgAck && (cmd.acc == ACC_STS_RD))
        linkGen <= cfgRdata[STS_GEN_LSB +: SPEED_FW];
    end
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && !cfgAck) |=> (cfgReq && $stable(cfgAddr) && $stable(cfgWe) && $stable(cfgWdata)));

  // R9
  phy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phyReq && !phyAck) |=> (phyReq && $stable(phyWe) && $stable(phyWdata)));

  // R8
  gen_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(linkGen) |-> ($past(cmd.clrGen) || $past(cfgAck)));
endmodule

// File: rtl/lsb_ctrl.sv
module lsb_ctrl
  import lsb_pkg::*;
#(
  parameter int LINK_WAIT  = 1000000,
  parameter int POLL_LIMIT = 200,
  parameter int POLL_GAP   = 10000,
  parameter int HOLD_CYC   = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] targetGen,
  input  logic       linkUp,
  input  logic       skipSpeedPoll,
  input  logic       cfgAck,
  input  logic       phyAck,
  input  logic       spdBusy,
  output dp_cmd_t    cmd,
  output logic       trainEn,
  output logic       done,
  output logic       fail,
  output logic       rxRecover
);
  localparam int TMAX0 = (LINK_WAIT > HOLD_CYC) ? LINK_WAIT : HOLD_CYC;
  localparam int TMAX  = (TMAX0 > POLL_GAP) ? TMAX0 : POLL_GAP;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int PW    = $clog2(POLL_LIMIT + 1);

  st_e           st;
  logic [TW-1:0] tmrQ;
  logic [PW-1:0] pollQ;
  logic          gen2Q;
  logic          busy;

  assign busy      = (st != S_IDLE);
  assign rxRecover = (st == S_HOLD) || (st == S_OVR_RD2) || (st == S_OVR_WR2);
  assign cmd.clrGen = (st == S_IDLE) && start;

  always_comb begin
    case (st)
      S_CAP_RD1, S_CAP_RD2: cmd.acc = ACC_CAP_RD;
      S_CAP_WR1:            cmd.acc = ACC_CAP_LO;
      S_CAP_WR2:            cmd.acc = ACC_CAP_HI;
      S_SPD_RD, S_POLL:     cmd.acc = ACC_SPD_RD;
      S_SPD_WR:             cmd.acc = ACC_SPD_SET;
      S_STS_RD:             cmd.acc = ACC_STS_RD;
      S_OVR_RD1, S_OVR_RD2: cmd.acc = ACC_PHY_RD;
      S_OVR_WR1:            cmd.acc = ACC_PHY_SET;
      S_OVR_WR2:            cmd.acc = ACC_PHY_CLR;
      default:              cmd.acc = ACC_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= S_IDLE;
      tmrQ    <= '0;
      pollQ   <= '0;
      gen2Q   <= 1'b0;
      trainEn <= 1'b0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st      <= S_CAP_RD1;
          gen2Q   <= (targetGen == 2'd2);
          done    <= 1'b0;
          fail    <= 1'b0;
          trainEn <= 1'b0;
        end
        S_CAP_RD1: if (cfgAck) st <= S_CAP_WR1;
        S_CAP_WR1: if (cfgAck) begin
          st      <= S_WAIT1;
          trainEn <= 1'b1;
          tmrQ    <= '0;
        end
        S_WAIT1, S_WAIT2: begin
          if (linkUp) st <= (st == S_WAIT1 && gen2Q) ? S_CAP_RD2 : S_STS_RD;
          else if (tmrQ == TW'(LINK_WAIT - 1)) begin
            st      <= S_OVR_RD1;
            trainEn <= 1'b0;
          end else tmrQ <= tmrQ + 1'b1;
        end
        S_CAP_RD2: if (cfgAck) st <= S_CAP_WR2;
        S_CAP_WR2: if (cfgAck) st <= S_SPD_RD;
        S_SPD_RD:  if (cfgAck) st <= S_SPD_WR;
        S_SPD_WR: if (cfgAck) begin
          tmrQ  <= '0;
          pollQ <= '0;
          st    <= skipSpeedPoll ? S_WAIT2 : S_POLL;
        end
        S_POLL: if (cfgAck) begin
          pollQ <= pollQ + 1'b1;
          tmrQ  <= '0;
          if (!spdBusy) st <= S_WAIT2;
          else if (pollQ == PW'(POLL_LIMIT - 1)) begin
            st      <= S_OVR_RD1;
            trainEn <= 1'b0;
          end else st <= S_GAP;
        end
        S_GAP: begin
          if (tmrQ == TW'(POLL_GAP - 1)) st <= S_POLL;
          else tmrQ <= tmrQ + 1'b1;
        end
        S_STS_RD: if (cfgAck) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        S_OVR_RD1: if (phyAck) st <= S_OVR_WR1;
        S_OVR_WR1: if (phyAck) begin
          st   <= S_HOLD;
          tmrQ <= '0;
        end
        S_HOLD: begin
          if (tmrQ == TW'(HOLD_CYC - 1)) st <= S_OVR_RD2;
          else tmrQ <= tmrQ + 1'b1;
        end
        S_OVR_RD2: if (phyAck) st <= S_OVR_WR2;
        S_OVR_WR2: if (phyAck) begin
          st   <= S_IDLE;
          done <= 1'b1;
          fail <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  fail_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> done);

  // R3
  link_wait_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((st == S_WAIT1) || (st == S_WAIT2)) |-> (tmrQ < TW'(LINK_WAIT)));

  // R5
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollQ <= PW'(POLL_LIMIT));

  // R11
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R9
  rx_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxRecover) |-> $past(phyAck));
endmodule

// File: rtl/link_speed_bringup.sv
module link_speed_bringup
  import lsb_pkg::*;
#(
  parameter int CFG_AW     = 12,
  parameter int CFG_DW     = 32,
  parameter int PHY_AW     = 16,
  parameter int PHY_DW     = 16,
  parameter int LINK_WAIT  = 1000000,
  parameter int POLL_LIMIT = 200,
  parameter int POLL_GAP   = 10000,
  parameter int HOLD_CYC   = 250000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [1:0]          targetGen,
  input  logic                linkUp,
  input  logic                skipSpeedPoll,
  output logic                trainEn,
  output logic                done,
  output logic                fail,
  output logic [SPEED_FW-1:0] linkGen,
  output logic                rxRecover,
  output logic                cfgReq,
  output logic                cfgWe,
  output logic [CFG_AW-1:0]   cfgAddr,
  output logic [CFG_DW-1:0]   cfgWdata,
  input  logic [CFG_DW-1:0]   cfgRdata,
  input  logic                cfgAck,
  output logic                phyReq,
  output logic                phyWe,
  output logic [PHY_AW-1:0]   phyAddr,
  output logic [PHY_DW-1:0]   phyWdata,
  input  logic [PHY_DW-1:0]   phyRdata,
  input  logic                phyAck
);
  dp_cmd_t cmd;
  logic    spdBusy;

  lsb_ctrl #(
    .LINK_WAIT(LINK_WAIT), .POLL_LIMIT(POLL_LIMIT),
    .POLL_GAP(POLL_GAP), .HOLD_CYC(HOLD_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .targetGen(targetGen),
    .linkUp(linkUp), .skipSpeedPoll(skipSpeedPoll), .cfgAck(cfgAck),
    .phyAck(phyAck), .spdBusy(spdBusy), .cmd(cmd), .trainEn(trainEn),
    .done(done), .fail(fail), .rxRecover(rxRecover)
  );

  lsb_datapath #(
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .PHY_AW(PHY_AW), .PHY_DW(PHY_DW)
  ) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .cfgReq(cfgReq), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .cfgAck(cfgAck),
    .phyReq(phyReq), .phyWe(phyWe), .phyAddr(phyAddr), .phyWdata(phyWdata),
    .phyRdata(phyRdata), .phyAck(phyAck),
    .spdBusy(spdBusy), .linkGen(linkGen)
  );
endmodule

// File: tb/tb_link_speed_bringup.sv
`timescale 1ns/1ps
module tb_link_speed_bringup;
  localparam int LW = 20;
  localparam int PL = 4;
  localparam int PG = 3;
  localparam int HC = 30;

  logic        clk = 0;
  logic        rstN = 0;
  logic        start = 0;
  logic [1:0]  targetGen = 2'd1;
  logic        linkUp;
  logic        skipSpeedPoll = 0;
  logic        trainEn, done, fail, rxRecover;
  logic [3:0]  linkGen;
  logic        cfgReq, cfgWe, cfgAck = 0;
  logic [11:0] cfgAddr;
  logic [31:0] cfgWdata, cfgRdata = 0;
  logic        phyReq, phyWe, phyAck = 0;
  logic [15:0] phyAddr, phyWdata, phyRdata = 0;

  int tests = 0;
  int errors = 0;

  always #5 clk = ~clk;

  link_speed_bringup #(
    .LINK_WAIT(LW), .POLL_LIMIT(PL), .POLL_GAP(PG), .HOLD_CYC(HC)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .targetGen(targetGen),
    .linkUp(linkUp), .skipSpeedPoll(skipSpeedPoll), .trainEn(trainEn),
    .done(done), .fail(fail), .linkGen(linkGen), .rxRecover(rxRecover),
    .cfgReq(cfgReq), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .cfgAck(cfgAck), .phyReq(phyReq), .phyWe(phyWe),
    .phyAddr(phyAddr), .phyWdata(phyWdata), .phyRdata(phyRdata), .phyAck(phyAck)
  );

  // Configuration set by tasks only
  logic        reload = 0;
  logic        linkEn = 0;
  logic [31:0] capInit, spdInit, stsInit;
  logic [15:0] phyInit;
  int          clearAfter, retrainLen;

  // Register / link model state, written only by the model block
  logic [31:0] capReg, spdReg, stsReg, capAtTrain, spdWrVal;
  logic [15:0] phyReg, phySetVal, phyClrVal;
  int          cyc = 0, capWr, spdWr, spdReads, setReads, phyWr, retrainCnt = 0;
  int          phyCyc0, phyCyc1;
  logic        trainPrev, capW2Link, rxSeen, rxEarly, doneWhileDown;

  assign linkUp = linkEn && (retrainCnt == 0);

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    cfgAck <= 1'b0;
    phyAck <= 1'b0;
    trainPrev <= trainEn;
    if (retrainCnt != 0) retrainCnt <= retrainCnt - 1;
    if (reload) begin
      capReg <= capInit; spdReg <= spdInit; stsReg <= stsInit; phyReg <= phyInit;
      capWr <= 0; spdWr <= 0; spdReads <= 0; setReads <= 0; phyWr <= 0;
      retrainCnt <= 0; capAtTrain <= '0; spdWrVal <= '0; capW2Link <= 1'b0;
      rxSeen <= 1'b0; rxEarly <= 1'b0; doneWhileDown <= 1'b0;
      phySetVal <= '0; phyClrVal <= '0; phyCyc0 <= 0; phyCyc1 <= 0;
    end else begin
      if (trainEn && !trainPrev) capAtTrain <= capReg;
      if (rxRecover) begin
        if (phyWr == 1) rxSeen <= 1'b1;
        else if (phyWr == 0) rxEarly <= 1'b1;
      end
      if (done && linkEn && !linkUp) doneWhileDown <= 1'b1;
      if (cfgReq && !cfgAck) begin
        cfgAck <= 1'b1;
        if (cfgWe) begin
          if (cfgAddr == 12'h07C) begin
            capReg <= cfgWdata;
            capWr  <= capWr + 1;
            if (cfgWdata[3:0] == 4'd2) capW2Link <= linkUp;
          end else if (cfgAddr == 12'h80C) begin
            spdReg   <= cfgWdata;
            spdWr    <= spdWr + 1;
            spdWrVal <= cfgWdata;
            setReads <= 0;
            if (cfgWdata[17]) retrainCnt <= retrainLen;
          end
        end else begin
          case (cfgAddr)
            12'h07C: cfgRdata <= capReg;
            12'h080: cfgRdata <= stsReg;
            12'h80C: begin
              spdReads <= spdReads + 1;
              if (spdReg[17] && clearAfter >= 0 && setReads >= clearAfter) begin
                spdReg[17] <= 1'b0;
                cfgRdata   <= spdReg & ~(32'h1 << 17);
              end else begin
                cfgRdata <= spdReg;
                setReads <= setReads + 1;
              end
            end
            default: cfgRdata <= 32'hDEAD_BEEF;
          endcase
        end
      end
      if (phyReq && !phyAck) begin
        phyAck <= 1'b1;
        if (phyWe) begin
          phyReg <= phyWdata;
          if (phyWr == 0) begin phySetVal <= phyWdata; phyCyc0 <= cyc; end
          else begin phyClrVal <= phyWdata; phyCyc1 <= cyc; end
          phyWr <= phyWr + 1;
        end else phyRdata <= phyReg;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic setModel(input logic [31:0] cap, input logic [31:0] spd, input logic [31:0] sts,
                          input int clr, input int retr, input logic [15:0] phy);
    capInit = cap; spdInit = spd; stsInit = sts; clearAfter = clr; retrainLen = retr; phyInit = phy;
    @(negedge clk) reload = 1;
    @(negedge clk) reload = 0;
  endtask

  task automatic runOnce(input logic [1:0] tg, input logic skp);
    @(negedge clk);
    targetGen = tg; skipSpeedPoll = skp; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic tReset();
    chk(!done && !fail && !trainEn, "R1 done/fail/trainEn", {done, fail, trainEn}, 0);
    chk(!rxRecover && !cfgReq && !phyReq, "R1 rxRecover/req", {rxRecover, cfgReq, phyReq}, 0);
    chk(linkGen == 0, "R1 linkGen", linkGen, 0);
  endtask

  task automatic tGen1();
    setModel(32'hABCD_1233, 32'h0, 32'h0011_0000, 0, 0, 16'h0);
    linkEn = 0;
    runOnce(2'd1, 0);
    @(posedge trainEn);
    @(negedge clk);
    chk(capReg == 32'hABCD_1231, "R2 cap field forced to 1", capReg, 32'hABCD_1231);
    @(negedge clk);
    chk(capAtTrain == 32'hABCD_1231, "R2 cap before trainEn", capAtTrain, 32'hABCD_1231);
    linkEn = 1;
    waitDone();
    chk(done && !fail, "R10 gen1 success", {done, fail}, 2'b10);
    chk(linkGen == 4'd1, "R8 linkGen gen1", linkGen, 1);
    chk(spdWr == 0 && spdReads == 0, "R10 target1 no 0x80C access", spdWr + spdReads, 0);
  endtask

  task automatic tGen2();
    setModel(32'h0000_0F01, 32'h0000_00A5, 32'h1042_0000, 2, 4, 16'h0);
    linkEn = 1;
    runOnce(2'd2, 0);
    waitDone();
    chk(capReg[3:0] == 4'd2 && capReg[31:4] == 28'h0000_0F0, "R4 cap field 2", capReg, 32'h0000_0F02);
    chk(capW2Link, "R4 cap raised after link-up", capW2Link, 1);
    chk(spdWrVal == 32'h0002_00A5, "R4 speed change write", spdWrVal, 32'h0002_00A5);
    chk(spdReads == 4, "R5 poll until clear", spdReads, 4);
    chk(done && !fail, "R7 gen2 success", {done, fail}, 2'b10);
    chk(!doneWhileDown, "R7 done after second link-up", doneWhileDown, 0);
    chk(linkGen == 4'd2, "R8 linkGen gen2", linkGen, 2);
  endtask

  task automatic tLastPoll();
    setModel(32'h0, 32'h0, 32'h0002_0000, PL - 1, 0, 16'h0);
    linkEn = 1;
    runOnce(2'd2, 0);
    waitDone();
    chk(spdReads == 1 + PL, "R5 clear on last poll counted", spdReads, 1 + PL);
    chk(done && !fail, "R5 clear on last poll wins", {done, fail}, 2'b10);
  endtask

  task automatic tSkip();
    setModel(32'h0, 32'h0, 32'h0003_0000, -1, 8, 16'h0);
    linkEn = 1;
    runOnce(2'd2, 1);
    waitDone();
    chk(spdReads == 1, "R6 no poll when skipped", spdReads, 1);
    chk(done && !fail, "R6 skip success", {done, fail}, 2'b10);
    chk(!doneWhileDown, "R7 waits out retrain", doneWhileDown, 0);
    chk(linkGen == 4'd3, "R8 linkGen skip", linkGen, 3);
  endtask

  task automatic tPollFail();
    setModel(32'h0, 32'h0, 32'h0002_0000, -1, 0, 16'h00C4);
    linkEn = 1;
    runOnce(2'd2, 0);
    waitDone();
    chk(spdReads == 1 + PL, "R5 poll limit", spdReads, 1 + PL);
    chk(done && fail, "R10 fail with done", {done, fail}, 2'b11);
    chk(!trainEn, "R5 trainEn dropped on fail", trainEn, 0);
    chk(phySetVal == 16'h00EC, "R9 override set", phySetVal, 16'h00EC);
    chk(phyClrVal == 16'h00C4, "R9 override clear", phyClrVal, 16'h00C4);
    chk(phyCyc1 - phyCyc0 >= HC && phyCyc1 - phyCyc0 <= HC + 8, "R9 hold time", phyCyc1 - phyCyc0, HC);
    chk(rxSeen && !rxEarly && !rxRecover, "R9 rxRecover window", {rxSeen, rxEarly, rxRecover}, 3'b100);
  endtask

  task automatic tLinkTimeout();
    setModel(32'h0, 32'h0, 32'h0001_0000, 0, 0, 16'h0001);
    linkEn = 0;
    runOnce(2'd2, 0);
    waitDone();
    chk(done && fail, "R3 timeout fails", {done, fail}, 2'b11);
    chk(capWr == 1 && capReg[3:0] == 4'd1, "R3 no speed raise after timeout", capReg, 1);
    chk(phyClrVal == 16'h0001, "R9 clear keeps others", phyClrVal, 16'h0001);
  endtask

  task automatic tEdgeLink(input int late);
    setModel(32'h0, 32'h0, 32'h0001_0000, 0, 0, 16'h0);
    linkEn = 0;
    runOnce(2'd1, 0);
    @(posedge trainEn);
    repeat (LW - 1 + late) @(posedge clk);
    @(negedge clk) linkEn = 1;
    waitDone();
    if (late == 0) chk(done && !fail, "R3 link-up in last cycle wins", {done, fail}, 2'b10);
    else           chk(done && fail, "R3 link-up one cycle late", {done, fail}, 2'b11);
  endtask

  task automatic tRetrainFail();
    setModel(32'h0, 32'h0, 32'h0002_0000, -1, 200, 16'h0);
    linkEn = 1;
    runOnce(2'd2, 1);
    waitDone();
    chk(done && fail, "R7 second wait timeout", {done, fail}, 2'b11);
  endtask

  task automatic tStartBusy();
    setModel(32'h0, 32'h0, 32'h0001_0000, 0, 0, 16'h0);
    linkEn = 0;
    runOnce(2'd1, 0);
    repeat (6) @(negedge clk);
    runOnce(2'd2, 0);
    repeat (2) @(negedge clk);
    linkEn = 1;
    waitDone();
    chk(capWr == 1, "R11 mid-run start ignored", capWr, 1);
    chk(spdWr == 0 && done && !fail, "R11 run unchanged", {spdWr[3:0], done, fail}, 6'b000010);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, errors);
    $finish;
  end

  initial begin
    capInit = 0; spdInit = 0; stsInit = 0; phyInit = 0; clearAfter = 0; retrainLen = 0;
    repeat (4) @(negedge clk);
    tReset();
    rstN = 1;
    @(negedge clk);
    tGen1();
    tGen2();
    tLastPoll();
    tSkip();
    tPollFail();
    tLinkTimeout();
    tEdgeLink(0);
    tEdgeLink(1);
    tRetrainFail();
    tStartBusy();
    $display("[TB] %0d tests run, %0d failed", tests, errors);
    $finish;
  end
endmodule